// File: doc/BRIEF.md
# Pre-Encoded Radix-4 Coefficient Multiplier

This block multiplies an n-bit two's-complement operand by one of a fixed set of signed coefficients. The set is chosen when the design is built. It is meant for filter and transform kernels that apply the same constants again and again. Each coefficient is converted to radix-4 signed digits while the design elaborates, and the result is kept in an internal read-only table. No digit recoding happens in the datapath at run time.

Every digit except the most significant one takes one of four values, {-2, -1, 0, +1}, and is stored in two bits. The top digit keeps the five-value set {-2..+2}, so that the whole two's-complement range can be reached. The operand produces one partial product per digit, n/2 in total. Each partial product is sign-extended to 2n bits, and a negative one is made by bitwise inversion plus a 1 injected at its lowest weight. The rows are summed and the sum is registered.

The caller presents a table address, an operand and a valid strobe. The 2n-bit product appears with its own valid flag one clock later.

Top module: `nr4_coef_mul`

## Requirements
- R1: While the synchronous active-low reset is low at a rising edge, `out_valid` and `product` are cleared to 0 at that edge.
- R2: When `in_valid` is 1 at a rising edge, `out_valid` is 1 after that edge. `product` then holds the exact signed 2n-bit product of the coefficient at `coef_addr` and `operand_a`. A new operation may start every cycle.
- R3: The coefficient at table index i is defined in n bits as follows: index 0 is the most negative value, index 1 the most positive value, index 2 is -1, index 3 is 0, index 4 is +1. Every other index holds the low n bits of i*i*29 + i*113 + 7, read as signed.
- R4: Extreme operands give exact results. In particular, the most negative coefficient times the most negative operand gives +2^(2n-2).
- R5: When `in_valid` is 0 at a rising edge, `out_valid` is 0 after it and `product` keeps its previous value, whatever `coef_addr` and `operand_a` carry.
- R6: A zero operand, or the zero coefficient at index 3, gives a product of 0.
- R7: The top digit of each coefficient covers the full range. The most positive coefficient at index 1 and the -1 coefficient at index 2 give exact products for every operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| coef_addr | input | ADDR_W ($clog2(DEPTH)) | Coefficient table index |
| operand_a | input | WIDTH | Signed multiplicand |
| out_valid | output | 1 | Product valid, one cycle after the request |
| product | output | 2*WIDTH | Signed product |

## Verification
Every result is due exactly one rising edge after its request, because the only register is the output stage. The bench drives the inputs on a falling edge and reads `product` and `out_valid` on the next falling edge. It keeps `in_valid` high without pauses, so each sample belongs to exactly one request. The hold and reset checks use the same one-edge delay: the inputs are changed with the strobe low, or the reset is pulled low, and the outputs are read at the following falling edge.

// File: rtl/nr4_mul_pkg.sv
// Package nr4_mul_pkg
// Holds the coefficient definition and the elaboration-time digit encoder.
// Assumes an even operand width between 4 and 32 bits.
package nr4_mul_pkg;

    // Raw n-bit pattern of the coefficient at a table index.
    function automatic logic [63:0] coef_bits(input int idx, input int width);
        logic [63:0] mask;
        logic [63:0] val;
        mask = (64'd1 << width) - 64'd1;
        case (idx)
            0:       val = 64'd1 << (width - 1);
            1:       val = (64'd1 << (width - 1)) - 64'd1;
            2:       val = mask;
            3:       val = 64'd0;
            4:       val = 64'd1;
            default: val = 64'(idx) * 64'(idx) * 64'd29 + 64'(idx) * 64'd113 + 64'd7;
        endcase
        return val & mask;
    endfunction

    // Builds the stored code word from an n-bit pattern.
    // Low digits use {neg,pos} pairs (value pos - 2*neg).
    // The top digit uses {sign,one,two}.
    function automatic logic [63:0] encode_coef(input logic [63:0] bits, input int width);
        logic [63:0] word;
        int k;
        int carry;
        int t;
        int s;
        int lo;
        int nn;
        int c1;
        int top;
        word  = '0;
        k     = width / 2;
        carry = 0;
        for (int j = 0; j < k - 1; j++) begin
            t     = int'(bits[2*j]) + carry;
            lo    = t % 2;
            c1    = t / 2;
            s     = int'(bits[2*j+1]) + c1;
            nn    = s % 2;
            carry = (s + nn) / 2;
            word[2*j]   = (lo != 0);
            word[2*j+1] = (nn != 0);
        end
        top = -2 * int'(bits[width-1]) + int'(bits[width-2]) + carry;
        word[2*k-2] = (top == 2) || (top == -2);
        word[2*k-1] = (top == 1) || (top == -1);
        word[2*k]   = (top < 0);
        return word;
    endfunction

endpackage

// File: rtl/nr4_coef_rom.sv
// Module nr4_coef_rom
// Combinational coefficient table. The code words are computed at
// elaboration by the package encoder. Assumes DEPTH is a power of two.
module nr4_coef_rom #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int WORD_W = WIDTH + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] code
);
    import nr4_mul_pkg::*;

    logic [WORD_W-1:0] table_q [DEPTH];

    // One constant entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [63:0] ENTRY = encode_coef(coef_bits(i, WIDTH), WIDTH);
        assign table_q[i] = ENTRY[WORD_W-1:0];
    end

    // Table lookup.
    always_comb begin
        code = table_q[addr];
    end
endmodule

// File: rtl/nr4_pp_gen.sv
// Module nr4_pp_gen
// Builds one 2n-bit row per digit, already shifted to weight 4^j.
// A negated row is given in inverted form, and its +1 correction is
// reported on neg_inj for the summer to add.
module nr4_pp_gen #(
    parameter int WIDTH = 8,
    parameter int K = WIDTH / 2,
    parameter int WORD_W = WIDTH + 1,
    parameter int PROD_W = 2 * WIDTH
) (
    input  logic [WIDTH-1:0]           a,
    input  logic [WORD_W-1:0]          code,
    output logic [K-1:0][PROD_W-1:0]   rows,
    output logic [K-1:0]               neg_inj
);
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] a2_ext;

    // Sign-extended operand and its double.
    always_comb begin
        a_ext  = PROD_W'($signed(a));
        a2_ext = a_ext <<< 1;
    end

    for (genvar j = 0; j < K; j++) begin : g_digit
        logic               neg;
        logic [PROD_W-1:0]  mag;
        if (j < K - 1) begin : g_low
            // Four-value selector: 0, +A, -A or -2A.
            always_comb begin
                neg = code[2*j+1];
                if (code[2*j])
                    mag = a_ext;
                else if (code[2*j+1])
                    mag = a2_ext;
                else
                    mag = '0;
            end
        end else begin : g_top
            // Five-value selector for the top digit.
            always_comb begin
                neg = code[WORD_W-1];
                if (code[WORD_W-2])
                    mag = a_ext;
                else if (code[WORD_W-3])
                    mag = a2_ext;
                else
                    mag = '0;
            end
        end
        // Conditional inversion and placement at weight 4^j.
        always_comb begin
            rows[j]    = (mag ^ {PROD_W{neg}}) << (2 * j);
            neg_inj[j] = neg;
        end
    end
endmodule

// File: rtl/nr4_pp_sum.sv
// Module nr4_pp_sum
// Adds the rows and the negation corrections, modulo 2^PROD_W.
// Assumes the rows are already sign-extended and shifted.
module nr4_pp_sum #(
    parameter int K = 4,
    parameter int PROD_W = 16
) (
    input  logic [K-1:0][PROD_W-1:0] rows,
    input  logic [K-1:0]             neg_inj,
    output logic [PROD_W-1:0]        sum
);
    // Sum of all rows plus a 1 at the lowest bit of each negated row.
    always_comb begin
        sum = '0;
        for (int j = 0; j < K; j++) begin
            sum = sum + rows[j] + (PROD_W'(neg_inj[j]) << (2 * j));
        end
    end
endmodule

// File: rtl/nr4_coef_mul.sv
// Module nr4_coef_mul
// Top level: table lookup, row generation and summation, followed by
// one output register. Assumes an even WIDTH from 4 to 32 and a DEPTH
// that is a power of two.
module nr4_coef_mul #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    coef_addr,
    input  logic [WIDTH-1:0]     operand_a,
    output logic                 out_valid,
    output logic [2*WIDTH-1:0]   product
);
    localparam int K      = WIDTH / 2;
    localparam int WORD_W = 2 * (K - 1) + 3;
    localparam int PROD_W = 2 * WIDTH;

    logic [WORD_W-1:0]          code;
    logic [K-1:0][PROD_W-1:0]   rows;
    logic [K-1:0]               neg_inj;
    logic [PROD_W-1:0]          sum;

    nr4_coef_rom #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rom (
        .addr (coef_addr),
        .code (code)
    );

    nr4_pp_gen #(.WIDTH(WIDTH), .K(K), .WORD_W(WORD_W), .PROD_W(PROD_W)) u_pp (
        .a       (operand_a),
        .code    (code),
        .rows    (rows),
        .neg_inj (neg_inj)
    );

    nr4_pp_sum #(.K(K), .PROD_W(PROD_W)) u_sum (
        .rows    (rows),
        .neg_inj (neg_inj),
        .sum     (sum)
    );

    // Output register: capture the sum on a request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                product <= sum;
        end
    end
endmodule

// File: rtl/nr4_coef_mul_chk.sv
// Module nr4_coef_mul_chk
// Temporal checks on the ports of nr4_coef_mul. It is attached by bind.
module nr4_coef_mul_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [ADDR_W-1:0]    coef_addr,
    input logic [WIDTH-1:0]     operand_a,
    input logic                 out_valid,
    input logic [2*WIDTH-1:0]   product
);
    localparam logic [WIDTH-1:0]   A_MIN   = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [2*WIDTH-1:0] MIN_SQ  = {2'b01, {(2*WIDTH-2){1'b0}}};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

    p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand_a == '0) |=> product == '0);

    p_zero_coef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef_addr == ADDR_W'(3)) |=> product == '0);

    p_unit_coef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef_addr == ADDR_W'(4)) |=>
        product == {{WIDTH{$past(operand_a[WIDTH-1])}}, $past(operand_a)});

    p_min_square_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef_addr == '0 && operand_a == A_MIN) |=> product == MIN_SQ);
endmodule

bind nr4_coef_mul nr4_coef_mul_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .coef_addr (coef_addr),
    .operand_a (operand_a),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/sim_nr4_coef_mul.sv
// Bench sim_nr4_coef_mul
// Exhaustive sweep over every table index and every operand, with
// expected products computed by plain signed arithmetic.
module sim_nr4_coef_mul;
    localparam int WIDTH  = 8;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PW     = 2 * WIDTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] coef_addr = '0;
    logic [WIDTH-1:0]  operand_a = '0;
    logic              out_valid;
    logic [PW-1:0]     product;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    nr4_coef_mul #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_addr(coef_addr),
        .operand_a(operand_a), .out_valid(out_valid), .product(product)
    );

    always #5 clk = ~clk;

    // Coefficient value per R3, as a signed number.
    function automatic longint coef_of(input int i);
        longint raw;
        longint half;
        half = longint'(1) << (WIDTH - 1);
        case (i)
            0: return -half;
            1: return half - 1;
            2: return -1;
            3: return 0;
            4: return 1;
            default: begin
                raw = (longint'(i) * i * 29 + longint'(i) * 113 + 7) % (2 * half);
                return (raw >= half) ? raw - 2 * half : raw;
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] keep;
        longint av;
        string tag;
        in_valid = 1'b1;
        coef_addr = ADDR_W'(1);
        operand_a = 8'h55;
        repeat (3) @(negedge clk);
        // R1: outputs are cleared while reset is held.
        check("R1 valid", {15'd0, out_valid}, '0);
        check("R1 product", product, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R4/R6/R7: every index times every operand, back to back.
        for (int ad = 0; ad < DEPTH; ad++) begin
            for (int v = 0; v < (1 << WIDTH); v++) begin
                in_valid  = 1'b1;
                coef_addr = ADDR_W'(ad);
                operand_a = WIDTH'(v);
                av = (v >= (1 << (WIDTH - 1))) ? longint'(v) - (1 << WIDTH) : longint'(v);
                @(negedge clk);
                if (v == 0 || ad == 3)            tag = "R6";
                else if (ad == 0 || v == 128 || v == 127) tag = "R4";
                else if (ad == 1 || ad == 2)      tag = "R7";
                else if (ad == 4 || ad > 4)       tag = "R3";
                else                              tag = "R2";
                check({tag, " product"}, product, PW'(coef_of(ad) * av));
                check("R2 valid", {15'd0, out_valid}, 16'd1);
            end
        end

        // R5: a strobe-low cycle leaves the product unchanged and clears valid.
        keep = product;
        in_valid  = 1'b0;
        coef_addr = ADDR_W'(7);
        operand_a = 8'h3C;
        @(negedge clk);
        check("R5 valid", {15'd0, out_valid}, '0);
        check("R5 product", product, keep);
        operand_a = 8'h80;
        coef_addr = ADDR_W'(0);
        @(negedge clk);
        check("R5 product held", product, keep);

        // R4: most negative squared, then R1 reset in mid-run.
        in_valid  = 1'b1;
        @(negedge clk);
        check("R4 min*min", product, 16'h4000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid valid", {15'd0, out_valid}, '0);
        check("R1 mid product", product, '0);
        in_valid = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule